// File: doc/BRIEF.md
# Vectored interrupt status unit

This block pairs a small processor status register with an eight-line vectored interrupt controller. It samples eight level-sensitive request lines on each rising clock edge. When nothing is pending, it records the lowest-numbered active line and raises a pending flag. That line number then stays frozen until the core acknowledges it.

Each line has its own handler address. The handler addresses sit in an eight-word table that the core fills with ordinary store-word writes to fixed addresses. When the pending and enable flags are both set, the unit raises a take-interrupt signal and presents the handler address of the latched line.

The same register also keeps the one-bit result of the compare-equal and compare-less instructions. The core writes that bit through a strobe.

Top module: `vis_unit`

## Requirements
- R1: After reset, `status_o` is 0, `take_int` is 0, `vector_o` is 0 and every table entry is 0.
- R2: While the pending flag is clear, a rising edge that sees any request line high sets the pending flag and latches a line number. Both are visible in the cycle after that edge. With no line high, the pending flag stays clear.
- R3: When several lines are high at once, the latched number is that of the lowest-numbered high line.
- R4: While the pending flag is set and `ack` is low, the pending flag and the line number hold, whatever the request lines do.
- R5: `ack` high at an edge while pending clears the pending flag after that edge, and the line number is kept. `ack` while nothing is pending has no effect.
- R6: `take_int` is 1 exactly when the pending and enable flags are both 1. `vector_o` equals the table entry of the latched line while `take_int` is 1, and is 0 otherwise.
- R7: A write with `wr_en` high to byte address `VEC_BASE + 2*k`, for k from 0 to 7 (default base 0xFF00), stores `wr_data` in entry k. Writes to any other address are ignored, and that includes odd addresses inside the range.
- R8: `cmp_we` high at an edge loads `cmp_val` into the compare flag.
- R9: `en_we` high at an edge loads `en_val` into the enable flag.
- R10: `status_o` packs the compare flag in bit 0, the pending flag in bit 1, the enable flag in bit 2 and the line number in bits 5:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 8 | Level-sensitive request lines, bit k is line k |
| wr_en | input | 1 | Store-word strobe |
| wr_addr | input | 16 | Store byte address |
| wr_data | input | 16 | Store data |
| cmp_we | input | 1 | Compare-result write strobe |
| cmp_val | input | 1 | Compare result to record |
| en_we | input | 1 | Enable-flag write strobe |
| en_val | input | 1 | Enable value to record |
| ack | input | 1 | Acknowledge of the pending request |
| status_o | output | 6 | Packed status register |
| line_o | output | 3 | Latched line number |
| take_int | output | 1 | Pending and enabled |
| vector_o | output | 16 | Handler address of the latched line, else 0 |

## Verification
Some properties are checked on every cycle. The vector stays 0 whenever no interrupt is taken. A request always captures when the unit is idle. Nothing captures without a request. The line number stays frozen until acknowledge, and acknowledge clears the pending flag. The compare and enable flags follow their strobes.

Other behaviour shows only in the bench scenarios. These include which line wins for each of the 256 request patterns, and the handler address that each line returns. They also include proof that stores outside the table, or at odd addresses, leave every entry untouched.

// File: rtl/vis_pkg.sv
package vis_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } vis_state_e;

endpackage

// File: rtl/vis_prio_enc.sv
module vis_prio_enc #(
    parameter int NUM_LINES = 8,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 any_req,
    output logic [LINE_W-1:0]    win_idx
);

    always_comb begin
        win_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = LINE_W'(i);
            end
        end
    end

    assign any_req = |req;

endmodule

// File: rtl/vis_vec_table.sv
module vis_vec_table #(
    parameter int          NUM_LINES = 8,
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] VEC_BASE  = 16'hFF00,
    localparam int         LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LINE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] entry_q [NUM_LINES];

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_entry
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(VEC_BASE) + ADDR_W'(2 * k);
        logic hit;
        assign hit = wr_en && (wr_addr == SLOT_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[k] <= '0;
            end else if (hit) begin
                entry_q[k] <= wr_data;
            end
        end
    end

    assign rd_data = entry_q[rd_idx];

endmodule

// File: rtl/vis_ctrl.sv
module vis_ctrl
    import vis_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [LINE_W-1:0] win_idx,
    input  logic              ack,
    output logic              pend,
    output logic [LINE_W-1:0] line_q
);

    vis_state_e state_q, state_d;
    logic       load_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_line) begin
                line_q <= win_idx;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        load_line = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin
                    state_d   = ST_HELD;
                    load_line = 1'b1;
                end
            end
            ST_HELD: begin
                if (ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pend = (state_q == ST_HELD);

endmodule

// File: rtl/vis_unit.sv
module vis_unit #(
    parameter int          NUM_LINES = 8,
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] VEC_BASE  = 16'hFF00,
    localparam int         LINE_W    = $clog2(NUM_LINES),
    localparam int         STAT_W    = LINE_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 cmp_we,
    input  logic                 cmp_val,
    input  logic                 en_we,
    input  logic                 en_val,
    input  logic                 ack,
    output logic [STAT_W-1:0]    status_o,
    output logic [LINE_W-1:0]    line_o,
    output logic                 take_int,
    output logic [DATA_W-1:0]    vector_o
);

    logic              any_req;
    logic [LINE_W-1:0] win_idx;
    logic              pend;
    logic [LINE_W-1:0] line_q;
    logic [DATA_W-1:0] rd_data;
    logic              cmp_q;
    logic              en_q;

    vis_prio_enc #(.NUM_LINES(NUM_LINES)) u_prio (
        .req     (irq_lines),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    vis_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (any_req),
        .win_idx (win_idx),
        .ack     (ack),
        .pend    (pend),
        .line_q  (line_q)
    );

    vis_vec_table #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .VEC_BASE  (VEC_BASE)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (line_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            if (cmp_we) cmp_q <= cmp_val;
            if (en_we)  en_q  <= en_val;
        end
    end

    assign take_int = pend & en_q;
    assign vector_o = take_int ? rd_data : '0;
    assign line_o   = line_q;
    assign status_o = {line_q, en_q, pend, cmp_q};

endmodule

// File: rtl/vis_unit_chk.sv
module vis_unit_chk #(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 16,
    parameter int LINE_W    = 3,
    parameter int STAT_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 cmp_we,
    input logic                 cmp_val,
    input logic                 en_we,
    input logic                 en_val,
    input logic                 ack,
    input logic [STAT_W-1:0]    status_o,
    input logic [LINE_W-1:0]    line_o,
    input logic                 take_int,
    input logic [DATA_W-1:0]    vector_o
);

    logic pend_w;
    assign pend_w = status_o[1];

    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !take_int |-> vector_o == '0); // R6
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_w && (|irq_lines)) |=> pend_w); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_w && irq_lines == '0) |=> !pend_w); // R2
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && !ack) |=> (pend_w && $stable(line_o))); // R4
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && ack) |=> !pend_w); // R5
    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> status_o[0] == $past(cmp_val)); // R8
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> status_o[2] == $past(en_val)); // R9

endmodule

bind vis_unit vis_unit_chk #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .LINE_W    (LINE_W),
    .STAT_W    (STAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .cmp_we    (cmp_we),
    .cmp_val   (cmp_val),
    .en_we     (en_we),
    .en_val    (en_val),
    .ack       (ack),
    .status_o  (status_o),
    .line_o    (line_o),
    .take_int  (take_int),
    .vector_o  (vector_o)
);

// File: tb/vis_unit_tb.sv
module vis_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_lines = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmp_we = 1'b0;
    logic        cmp_val = 1'b0;
    logic        en_we = 1'b0;
    logic        en_val = 1'b0;
    logic        ack = 1'b0;
    logic [5:0]  status_o;
    logic [2:0]  line_o;
    logic        take_int;
    logic [15:0] vector_o;

    int total = 0;
    int bad = 0;

    localparam logic [15:0] BASE = 16'hFF00;

    always #2 clk = ~clk;

    vis_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_we(cmp_we), .cmp_val(cmp_val), .en_we(en_we), .en_val(en_val),
        .ack(ack), .status_o(status_o), .line_o(line_o),
        .take_int(take_int), .vector_o(vector_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] p);
        for (int i = 0; i < 8; i++) if (p[i]) return i;
        return 0;
    endfunction

    function automatic logic [15:0] vec_val(input int k);
        return 16'h1000 + 16'(k * 16'h0123);
    endfunction

    task automatic store(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int last_line;
        repeat (3) @(posedge clk);
        #1;
        check("R1 status", status_o, 0);
        check("R1 take", take_int, 0);
        check("R1 vector", vector_o, 0);
        rst_n = 1'b1;
        tick();

        // R2: no request keeps idle; R5: ack while idle has no effect
        ack = 1'b1; tick(); ack = 1'b0;
        check("R2 idle", status_o[1], 0);
        check("R5 idle ack line", line_o, 0);

        // R3/R4/R5 sweep over every request pattern
        for (int p = 1; p < 256; p++) begin
            irq_lines = 8'(p);
            tick();
            check("R2 pend", status_o[1], 1);
            check("R3 line", line_o, lowest(8'(p)));
            irq_lines = ~8'(p);
            tick();
            check("R4 hold pend", status_o[1], 1);
            check("R4 hold line", line_o, lowest(8'(p)));
            irq_lines = '0; ack = 1'b1;
            tick();
            ack = 1'b0;
            check("R5 clear", status_o[1], 0);
            check("R5 keep line", line_o, lowest(8'(p)));
        end

        // R7: fill table, then stores that must be ignored
        for (int k = 0; k < 8; k++) store(BASE + 16'(2 * k), vec_val(k));
        store(BASE - 16'd2, 16'hDEAD);
        store(BASE + 16'd16, 16'hDEAD);
        store(BASE + 16'd1, 16'hDEAD);
        store(BASE + 16'd7, 16'hDEAD);

        // R6: pending but disabled -> no take, zero vector
        irq_lines = 8'h08; tick(); irq_lines = '0;
        check("R6 disabled take", take_int, 0);
        check("R6 disabled vec", vector_o, 0);
        // R9: enable
        en_we = 1'b1; en_val = 1'b1; tick(); en_we = 1'b0;
        check("R9 en set", status_o[2], 1);
        check("R6 take", take_int, 1);
        check("R7 vec 3", vector_o, vec_val(3));
        ack = 1'b1; tick(); ack = 1'b0;
        check("R6 after ack", take_int, 0);
        check("R6 after ack vec", vector_o, 0);

        for (int k = 0; k < 8; k++) begin
            irq_lines = 8'(1 << k) | 8'h80;
            tick();
            irq_lines = '0;
            check("R6 take k", take_int, 1);
            check("R7 vec k", vector_o, vec_val(k));
            ack = 1'b1; tick(); ack = 1'b0;
        end

        // R8: compare flag
        cmp_we = 1'b1; cmp_val = 1'b1; tick(); cmp_we = 1'b0;
        check("R8 cmp 1", status_o[0], 1);
        cmp_val = 1'b0; tick();
        check("R8 no strobe", status_o[0], 1);

        // R10: packing with line 5, all flags set
        irq_lines = 8'h20; tick(); irq_lines = '0;
        last_line = 5;
        check("R10 status", status_o, (last_line << 3) | 7);
        cmp_we = 1'b1; cmp_val = 1'b0; tick(); cmp_we = 1'b0;
        check("R8 cmp 0", status_o[0], 0);
        en_we = 1'b1; en_val = 1'b0; tick(); en_we = 1'b0;
        check("R9 en clear", status_o[2], 0);
        check("R6 take off", take_int, 0);
        check("R10 status2", status_o, (last_line << 3) | 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule